// File: doc/BRIEF.md
# AC97 Link Frame Controller

This block is the controller end of a five-wire AC97 audio link. The codec supplies the bit clock. The controller holds the codec in reset until its own reset is released, and it generates the frame sync strobe. On the outgoing serial line it sends a 16-bit tag slot followed by twelve 20-bit data slots. On the incoming serial line it splits the same structure back into slots. A frame is 256 bit clocks long, which is about 21 microseconds at the nominal 12.288 MHz bit clock and 48 kHz frame rate.

The host writes per-slot outgoing data through a strobe, a slot number and a 20-bit word. Each write marks its slot as carrying valid data, and the slot is sent in exactly one frame. The tag slot is built from those marks. Incoming slots that the codec's tag marks as valid come back to the host as single-cycle pulses with the slot number and the data. The controller sends no valid data until the codec's incoming tag reports that the codec is ready.

Top module: `ac97l_link`

## Requirements
- R1: `link_rst_n` is low while `rst_n` is low. It goes high on the second rising edge of `bit_clk` after `rst_n` is released. While `link_rst_n` is low, `frm_sync` and `ser_out` are low.
- R2: `frm_sync` rises together with the release of `link_rst_n`. It then repeats every 256 bit clocks and stays high for 16 bit clocks. It rises one bit clock before the tag MSB is sent.
- R3: Frame layout, counted in bit clocks from the tag MSB: tag bits 15..0 occupy positions 0..15. Data slot k (1..12) occupies positions 16+20(k-1) to 35+20(k-1). Every slot is sent MSB first.
- R4: In the outgoing tag, bit 15-k is set exactly when slot k carries valid data. Bit 15 is the OR of those bits, and bits 2..0 are zero. Slots not marked valid are sent as all zeros, whatever data they hold.
- R5: A write with `tx_wr` high and `tx_slot` in 1..12 stores `tx_data` and marks that slot for the next frame boundary. A slot is sent in exactly one frame and then cleared. The last write before a boundary wins.
- R6: A write with `tx_slot` equal to 0 or greater than 12 has no effect on any frame.
- R7: While `codec_ready` is low, every outgoing tag is zero. Pending slot writes are kept and go out in the first frame formed after `codec_ready` rises.
- R8: `codec_ready` follows bit 15 of the most recently received incoming tag and is low during and after reset until a tag with that bit set arrives.
- R9: `ser_in` is sampled on the falling edge of `bit_clk` using the R3 layout. For each slot k whose incoming tag bit 15-k is set, one `rx_valid` pulse is produced, with `rx_slot` = k and `rx_data` holding the slot MSB first, one bit clock after the slot's last bit.
- R10: An incoming data slot whose tag bit is clear produces no `rx_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock supplied by the codec |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| link_rst_n | output | 1 | Active-low cold reset driven to the codec |
| frm_sync | output | 1 | Frame sync strobe |
| ser_out | output | 1 | Outgoing serial slot data, changes on rising edge |
| ser_in | input | 1 | Incoming serial slot data, sampled on falling edge |
| tx_wr | input | 1 | Host write strobe for an outgoing slot |
| tx_slot | input | 4 | Outgoing slot number, 1..12 valid |
| tx_data | input | 20 | Outgoing slot word |
| rx_valid | output | 1 | One-cycle pulse for a received valid slot |
| rx_slot | output | 4 | Slot number of the received word |
| rx_data | output | 20 | Received slot word |
| codec_ready | output | 1 | Codec ready flag from the incoming tag |

## Verification
On every cycle, the assertions check that the link is quiet while the codec is in reset and that the sync strobe keeps its 16-cycle width and 256-cycle period. They also check that a frame formed before the codec is ready carries an empty tag, and that receive pulses are isolated and name a legal slot. The bench scenarios show the things that need a model of the serial stream: bit positions and MSB-first order, tag encoding, zeroing of slots not marked valid, the one-shot and last-write-wins handling of host writes, rejection of illegal slot numbers, and which incoming slots get reported with what data.

// File: rtl/ac97l_pkg.sv
package ac97l_pkg;
  localparam int SLOTS     = 12;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int SLOT_NW   = 4;
  localparam int FRAME_LEN = TAG_W + SLOTS * SLOT_W;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam int SYNC_LEN  = TAG_W;
  localparam int BIT_NW    = $clog2(SLOT_W);

  // slot index (0 = tag) that owns frame position p
  function automatic logic [SLOT_NW-1:0] slot_at(input logic [POS_W-1:0] p);
    if (int'(p) < TAG_W) return '0;
    return SLOT_NW'(1 + (int'(p) - TAG_W) / SLOT_W);
  endfunction

  // bit number inside the owning slot word; MSB goes out first
  function automatic logic [BIT_NW-1:0] bit_at(input logic [POS_W-1:0] p);
    if (int'(p) < TAG_W) return BIT_NW'(TAG_W - 1 - int'(p));
    return BIT_NW'(SLOT_W - 1 - (int'(p) - TAG_W) % SLOT_W);
  endfunction

  function automatic logic legal_slot(input logic [SLOT_NW-1:0] s);
    return (int'(s) >= 1) && (int'(s) <= SLOTS);
  endfunction
endpackage

// File: rtl/ac97l_rstgen.sv
module ac97l_rstgen #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic link_rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign link_rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ac97l_timer.sv
module ac97l_timer
  import ac97l_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [POS_W-1:0] pos,
  output logic             frm_sync,
  output logic             snap_evt
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pos <= LAST;
    else if (!run)         pos <= LAST;
    else if (pos == LAST)  pos <= '0;
    else                   pos <= pos + 1'b1;
  end

  assign frm_sync = run && ((pos == LAST) || (int'(pos) < SYNC_LEN - 1));
  assign snap_evt = run && (pos == LAST);
endmodule

// File: rtl/ac97l_tx.sv
module ac97l_tx
  import ac97l_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [POS_W-1:0]   pos,
  input  logic               snap_evt,
  input  logic               codec_ready,
  input  logic               wr,
  input  logic [SLOT_NW-1:0] wr_slot,
  input  logic [SLOT_W-1:0]  wr_data,
  output logic [TAG_W-1:0]   cur_tag,
  output logic               ser_out
);
  logic [SLOTS:1]            pend_v;
  logic [SLOTS:1]            fvld_v;
  logic [SLOTS*SLOT_W-1:0]   frm_flat;
  logic                      launch;

  assign launch = snap_evt && codec_ready;

  for (genvar k = 1; k <= SLOTS; k++) begin : g_slot
    logic              hit;
    logic              pend_q;
    logic              fvld_q;
    logic [SLOT_W-1:0] hold_q;
    logic [SLOT_W-1:0] frm_q;

    assign hit = wr && (wr_slot == SLOT_NW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        fvld_q <= 1'b0;
        hold_q <= '0;
        frm_q  <= '0;
      end else begin
        if (hit) hold_q <= wr_data;
        if (snap_evt) fvld_q <= launch && pend_q;
        if (launch) frm_q <= hold_q;
        if (hit)         pend_q <= 1'b1;
        else if (launch) pend_q <= 1'b0;
      end
    end

    assign pend_v[k] = pend_q;
    assign fvld_v[k] = fvld_q;
    assign frm_flat[(k-1)*SLOT_W +: SLOT_W] = frm_q;
  end

  always_comb begin
    cur_tag = '0;
    cur_tag[TAG_W-1] = |fvld_v;
    for (int k = 1; k <= SLOTS; k++) cur_tag[TAG_W-1-k] = fvld_v[k];
  end

  logic [SLOT_NW-1:0] cur_slot;
  logic [BIT_NW-1:0]  cur_bit;
  logic               ser_bit;

  always_comb begin
    cur_slot = slot_at(pos);
    cur_bit  = bit_at(pos);
    ser_bit  = 1'b0;
    if (cur_slot == '0)
      ser_bit = cur_tag[cur_bit[$clog2(TAG_W)-1:0]];
    else if (fvld_v[cur_slot])
      ser_bit = frm_flat[(int'(cur_slot) - 1) * SLOT_W + int'(cur_bit)];
  end

  assign ser_out = run && ser_bit;
endmodule

// File: rtl/ac97l_rx.sv
module ac97l_rx
  import ac97l_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [POS_W-1:0]   pos,
  input  logic               ser_in,
  output logic               slot_end,
  output logic               rx_valid,
  output logic [SLOT_NW-1:0] rx_slot,
  output logic [SLOT_W-1:0]  rx_data,
  output logic               codec_ready
);
  logic                smp;
  logic [SLOT_W-1:0]   sh;
  logic [SLOT_W-1:0]   word;
  logic [TAG_W-1:0]    tag_q;
  logic [SLOT_NW-1:0]  cur_slot;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp <= 1'b0;
    else        smp <= ser_in;
  end

  assign cur_slot = slot_at(pos);
  assign slot_end = run && (bit_at(pos) == '0);
  assign word     = {sh[SLOT_W-2:0], smp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh          <= '0;
      tag_q       <= '0;
      codec_ready <= 1'b0;
      rx_valid    <= 1'b0;
      rx_slot     <= '0;
      rx_data     <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (!run) begin
        sh          <= '0;
        tag_q       <= '0;
        codec_ready <= 1'b0;
      end else begin
        sh <= word;
        if (slot_end) begin
          if (cur_slot == '0) begin
            tag_q       <= word[TAG_W-1:0];
            codec_ready <= word[TAG_W-1];
          end else if (tag_q[TAG_W-1-int'(cur_slot)]) begin
            rx_valid <= 1'b1;
            rx_slot  <= cur_slot;
            rx_data  <= word;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ac97l_link.sv
module ac97l_link
  import ac97l_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  output logic               link_rst_n,
  output logic               frm_sync,
  output logic               ser_out,
  input  logic               ser_in,
  input  logic               tx_wr,
  input  logic [SLOT_NW-1:0] tx_slot,
  input  logic [SLOT_W-1:0]  tx_data,
  output logic               rx_valid,
  output logic [SLOT_NW-1:0] rx_slot,
  output logic [SLOT_W-1:0]  rx_data,
  output logic               codec_ready
);
  logic [POS_W-1:0] pos;
  logic             snap_evt;
  logic             slot_end;
  logic [TAG_W-1:0] cur_tag;
  logic             tx_ok;

  assign tx_ok = tx_wr && legal_slot(tx_slot);

  ac97l_rstgen #(.STAGES(RST_STAGES)) u_rst (
    .clk(bit_clk), .rst_n(rst_n), .link_rst_n(link_rst_n)
  );

  ac97l_timer u_tim (
    .clk(bit_clk), .rst_n(rst_n), .run(link_rst_n),
    .pos(pos), .frm_sync(frm_sync), .snap_evt(snap_evt)
  );

  ac97l_tx u_tx (
    .clk(bit_clk), .rst_n(rst_n), .run(link_rst_n), .pos(pos),
    .snap_evt(snap_evt), .codec_ready(codec_ready),
    .wr(tx_ok), .wr_slot(tx_slot), .wr_data(tx_data),
    .cur_tag(cur_tag), .ser_out(ser_out)
  );

  ac97l_rx u_rx (
    .clk(bit_clk), .rst_n(rst_n), .run(link_rst_n), .pos(pos),
    .ser_in(ser_in), .slot_end(slot_end),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data),
    .codec_ready(codec_ready)
  );
endmodule

// File: rtl/ac97l_chk.sv
module ac97l_chk
  import ac97l_pkg::*;
(
  input logic               bit_clk,
  input logic               rst_n,
  input logic               link_rst_n,
  input logic               frm_sync,
  input logic               ser_out,
  input logic               rx_valid,
  input logic [SLOT_NW-1:0] rx_slot,
  input logic               snap_evt,
  input logic               codec_ready,
  input logic [TAG_W-1:0]   cur_tag
);
  logic        prev_sync;
  logic        seen_rise;
  logic [POS_W:0] since_rise;
  logic [5:0]  hi_cnt;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sync  <= 1'b0;
      seen_rise  <= 1'b0;
      since_rise <= '0;
      hi_cnt     <= '0;
    end else begin
      prev_sync <= frm_sync;
      hi_cnt    <= frm_sync ? hi_cnt + 1'b1 : '0;
      if (frm_sync && !prev_sync) begin
        since_rise <= 1;
        seen_rise  <= 1'b1;
      end else if (since_rise != '1) begin
        since_rise <= since_rise + 1'b1;
      end
    end
  end

  p_quiet_in_reset_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !link_rst_n |-> (!frm_sync && !ser_out));

  p_sync_width_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!frm_sync && prev_sync) |-> (hi_cnt == 6'(SYNC_LEN)));

  p_sync_period_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (frm_sync && !prev_sync && seen_rise) |-> (since_rise == (POS_W+1)'(FRAME_LEN)));

  p_gate_before_ready_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (snap_evt && !codec_ready) |=> (cur_tag == '0));

  p_rx_slot_legal_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |-> (rx_slot >= 1 && int'(rx_slot) <= SLOTS));

  p_rx_isolated_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
endmodule

bind ac97l_link ac97l_chk u_chk (
  .bit_clk(bit_clk), .rst_n(rst_n), .link_rst_n(link_rst_n),
  .frm_sync(frm_sync), .ser_out(ser_out), .rx_valid(rx_valid),
  .rx_slot(rx_slot), .snap_evt(snap_evt), .codec_ready(codec_ready),
  .cur_tag(cur_tag)
);

// File: tb/tb_ac97l_link.sv
module tb_ac97l_link;
  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_rst_n, frm_sync, ser_out, rx_valid, codec_ready;
  logic        ser_in = 1'b0;
  logic        tx_wr = 1'b0;
  logic [3:0]  tx_slot = '0;
  logic [19:0] tx_data = '0;
  logic [3:0]  rx_slot;
  logic [19:0] rx_data;

  int checks = 0, errors = 0, cycles = 0, frames = 0;

  ac97l_link dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .link_rst_n(link_rst_n),
    .frm_sync(frm_sync), .ser_out(ser_out), .ser_in(ser_in),
    .tx_wr(tx_wr), .tx_slot(tx_slot), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_data(rx_data),
    .codec_ready(codec_ready)
  );

  always #10 bit_clk = ~bit_clk;

  // codec model state
  logic [15:0] codec_tag = '0;
  logic [19:0] codec_data [1:12];
  logic [7:0]  cpos = '0;
  logic        prev_s = 1'b0, have0 = 1'b0;
  logic [255:0] ob;
  logic [15:0] cap_tag;
  logic [19:0] cap_slot [1:12];
  logic [15:0] rx_mask;
  logic [19:0] rx_got [1:12];
  int hi_run = 0, hi_len = 0, since = 0, period = 0;
  logic last_s = 1'b0;

  initial for (int k = 1; k <= 12; k++) begin
    codec_data[k] = '0; cap_slot[k] = '0; rx_got[k] = '0;
  end

  function automatic logic codec_bit(input logic [7:0] p);
    int q;
    if (p < 16) return codec_tag[15 - p];
    q = int'(p) - 16;
    return codec_data[q / 20 + 1][19 - q % 20];
  endfunction

  // codec side drives after each rising edge
  always @(posedge bit_clk) begin
    #1;
    if (frm_sync && !prev_s) cpos = 8'd255;
    else cpos = cpos + 8'd1;
    prev_s = frm_sync;
    ser_in = codec_bit(cpos);
  end

  // monitor samples mid-cycle
  always @(negedge bit_clk) begin
    cycles++;
    if (rx_valid && rx_slot >= 1 && rx_slot <= 12) begin
      rx_mask[rx_slot] = 1'b1;
      rx_got[rx_slot] = rx_data;
    end
    if (frm_sync) hi_run++;
    else if (hi_run > 0) begin hi_len = hi_run; hi_run = 0; end
    if (frm_sync && !last_s) begin period = since; since = 1; end
    else since++;
    last_s = frm_sync;
    if (link_rst_n) begin
      ob[cpos] = ser_out;
      if (cpos == 8'd0) have0 = 1'b1;
      if (cpos == 8'd255 && have0) begin
        for (int i = 0; i < 16; i++) cap_tag[15 - i] = ob[i];
        for (int k = 1; k <= 12; k++)
          for (int j = 0; j < 20; j++)
            cap_slot[k][19 - j] = ob[16 + 20 * (k - 1) + j];
        frames++;
      end
    end
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int target = frames + n;
    while (frames < target) begin @(negedge bit_clk); #1; end
  endtask

  task automatic host_write(input logic [3:0] s, input logic [19:0] d);
    @(negedge bit_clk); #1;
    tx_wr = 1'b1; tx_slot = s; tx_data = d;
    @(negedge bit_clk); #1;
    tx_wr = 1'b0;
  endtask

  task automatic t_reset;
    repeat (4) @(negedge bit_clk);
    chk("R1 codec reset held", 32'(link_rst_n), 0);
    chk("R1 sync quiet", 32'(frm_sync), 0);
    chk("R1 data quiet", 32'(ser_out), 0);
    chk("R8 ready low in reset", 32'(codec_ready), 0);
    chk("R9 no rx in reset", 32'(rx_valid), 0);
    rst_n = 1'b1;
    @(negedge bit_clk);
    chk("R1 codec reset after one edge", 32'(link_rst_n), 0);
    @(negedge bit_clk);
    chk("R1 codec reset released", 32'(link_rst_n), 1);
    chk("R2 sync rises with release", 32'(frm_sync), 1);
  endtask

  task automatic t_timing;
    wait_frames(2);
    chk("R2 sync high width", 32'(hi_len), 16);
    chk("R2 sync period", 32'(period), 256);
  endtask

  task automatic t_not_ready;
    repeat (3) @(negedge bit_clk);
    host_write(4'd3, 20'hABCDE);
    wait_frames(2);
    chk("R7 tag empty before ready", 32'(cap_tag), 0);
    chk("R7 slot3 silent before ready", 32'(cap_slot[3]), 0);
    chk("R8 ready still low", 32'(codec_ready), 0);
  endtask

  task automatic t_ready;
    codec_tag = 16'h8000;
    wait_frames(2);
    chk("R8 ready follows tag", 32'(codec_ready), 1);
    chk("R7 pending slot sent after ready tag", 32'(cap_tag), 32'h9000);
    chk("R7 pending slot3 data", 32'(cap_slot[3]), 32'hABCDE);
    wait_frames(1);
    chk("R5 sent once tag", 32'(cap_tag), 0);
    chk("R5 sent once slot3", 32'(cap_slot[3]), 0);
  endtask

  task automatic t_multi;
    repeat (3) @(negedge bit_clk);
    host_write(4'd1, 20'h80001);
    host_write(4'd7, 20'h5A5A5);
    host_write(4'd12, 20'h00001);
    host_write(4'd7, 20'h12345);
    wait_frames(2);
    chk("R4 tag bits", 32'(cap_tag), 32'hC108);
    chk("R3 slot1 msb first", 32'(cap_slot[1]), 32'h80001);
    chk("R5 last write wins slot7", 32'(cap_slot[7]), 32'h12345);
    chk("R3 slot12 final bit", 32'(cap_slot[12]), 32'h00001);
    chk("R4 invalid slot3 zero", 32'(cap_slot[3]), 0);
  endtask

  task automatic t_bad_slot;
    repeat (3) @(negedge bit_clk);
    host_write(4'd0, 20'hFFFFF);
    host_write(4'd13, 20'hFFFFF);
    host_write(4'd15, 20'hFFFFF);
    wait_frames(2);
    chk("R6 illegal slots leave tag empty", 32'(cap_tag), 0);
    begin
      logic [19:0] any = '0;
      for (int k = 1; k <= 12; k++) any |= cap_slot[k];
      chk("R6 illegal slots leave data zero", 32'(any), 0);
    end
  endtask

  task automatic t_rx;
    codec_tag = 16'hC808;
    codec_data[1]  = 20'hFEDCB;
    codec_data[2]  = 20'h77777;
    codec_data[4]  = 20'h00F0F;
    codec_data[12] = 20'h80000;
    repeat (3) @(negedge bit_clk);
    rx_mask = '0;
    wait_frames(2);
    chk("R9 R10 reported slot set", 32'(rx_mask), 32'h1012);
    chk("R9 slot1 data", 32'(rx_got[1]), 32'hFEDCB);
    chk("R9 slot4 data", 32'(rx_got[4]), 32'h00F0F);
    chk("R9 slot12 data", 32'(rx_got[12]), 32'h80000);
    chk("R10 slot2 not reported", 32'(rx_mask[2]), 0);
  endtask

  task automatic t_drop_ready;
    codec_tag = 16'h0000;
    wait_frames(2);
    chk("R8 ready drops with tag", 32'(codec_ready), 0);
  endtask

  initial begin
    rx_mask = '0;
    t_reset();
    t_timing();
    t_not_ready();
    t_ready();
    t_multi();
    t_bad_slot();
    t_rx();
    t_drop_ready();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule